// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Controller

This block holds the configuration and selection logic of a clock fanout with two candidate input clocks and ten output copies. A three-wire control port (shift clock, serial data and a mode enable) decides which input clock is forwarded and which of the ten outputs drive it. A disabled output is modelled by a cleared output-enable bit and a low clock level. Clocks are treated as single-ended digital levels; the selection and gating paths are purely combinational.

With the mode enable high, the block is in programmable mode. An eleven-bit word is shifted in one bit per rising shift-clock edge. A twelfth edge commits it to a control register, after which the configuration is frozen. A shift-clock edge taken while the mode enable is low wipes the shift register, the control register and the pulse counter, and allows a new word to be loaded. While the mode enable is low, the control word is bypassed: every output runs, and the serial data pin picks the clock directly.

Top module: `clk_fanout_cfg`

## Requirements
- R1: While rst_ni is low, the pulse counter, shift register and control register are cleared. In programmable mode, the ports then show all ten oe_o bits at 1 and ref_clk0_i selected.
- R2: In programmable mode, every rising shift_clk_i edge before the commit places ser_data_i in the first shift stage and moves each other stage one place along. The first bit shifted therefore ends in the last stage.
- R3: The control register takes the shift register contents on the 12th rising shift_clk_i edge in programmable mode and not before. After exactly 11 edges the outputs still show the uncommitted state of R10. The value on ser_data_i at the 12th edge is not stored.
- R4: Number the committed bits k = 0..10 in the order they were shifted. For k in 0..9, bit k becomes oe_o[9-k].
- R5: Committed bit 10 selects the clock: 0 forwards ref_clk0_i and 1 forwards ref_clk1_i.
- R6: Each clk_o[j] equals the selected clock when oe_o[j] is 1, and is held at 0 when oe_o[j] is 0.
- R7: After the commit, further shift_clk_i edges in programmable mode, with any ser_data_i values, leave oe_o and the selection unchanged. The pulse counter saturates.
- R8: A rising shift_clk_i edge with prog_en_i low clears the counter, shift register and control register, including after a partial load. A full 12-edge sequence afterwards commits a new word.
- R9: With prog_en_i low, all oe_o bits are 1 and ser_data_i selects the clock combinationally (0 picks ref_clk0_i, 1 picks ref_clk1_i), with no shift edge needed. If prog_en_i goes low and then high again with no shift edge in between, the committed word is still in force.
- R10: In programmable mode before the commit, all oe_o bits are 1 and ref_clk0_i is selected, whatever has been shifted in.
- R11: With prog_en_i and ser_data_i both at their default low level, all outputs are enabled and ref_clk0_i is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_clk_i | input | 1 | Shift clock; also clocks the counter and the control register |
| ser_data_i | input | 1 | Serial configuration bit; selects the clock directly in standard mode |
| prog_en_i | input | 1 | Mode enable: 1 programmable, 0 standard |
| ref_clk0_i | input | 1 | Candidate clock 0 |
| ref_clk1_i | input | 1 | Candidate clock 1 |
| clk_o | output | 10 | Gated copies of the selected clock |
| oe_o | output | 10 | Per-output enable; 0 models a 3-stated output |

## Verification
An error in the shift order or the bit mapping shows only once a word is committed. The bench therefore checks oe_o and the selection right after the 12th edge for several asymmetric words. A counter that is off by one commits on the 11th edge or skips the 12th. This is visible one edge early or late, so the bench samples both after the 11th and after the 12th pulse. A missing freeze, or a soft reset that does not clear everything, shows on the first edge after the event. The mode and selection multiplexers are combinational, and a fault in them shows immediately when ser_data_i, prog_en_i or the static reference levels are toggled.

// File: rtl/cfo_pkg.sv
`timescale 1ns/1ps
package cfo_pkg;
  localparam int unsigned N_OUT_DEF = 10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_LOAD   = 2'd2,
    ST_LOCKED = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cfo_shift_reg.sv
`timescale 1ns/1ps
module cfo_shift_reg #(
  parameter int unsigned W = 11
) (
  input  logic         shift_clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q;
  logic [W-1:0] stage_d;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_d[i] = ser_i;
    end else begin : g_body
      assign stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge shift_clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[i] <= 1'b0;
      else if (clr_i)   stage_q[i] <= 1'b0;
      else if (shift_i) stage_q[i] <= stage_d[i];
    end
  end

  assign q_o = stage_q;

  // R2: serial bit enters stage 0, the rest move one place
  p_shift_order_r2: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i) |=> (stage_q[0] == $past(ser_i)) &&
                            (stage_q[W-1:1] == $past(stage_q[W-2:0])));
endmodule

// File: rtl/cfo_sequencer.sv
`timescale 1ns/1ps
module cfo_sequencer
  import cfo_pkg::*;
#(
  parameter int unsigned N_BITS = 11
) (
  input  logic shift_clk_i,
  input  logic rst_ni,
  input  logic prog_en_i,
  output logic shift_o,
  output logic load_o,
  output logic locked_o
);
  localparam int unsigned CNT_W = $clog2(N_BITS + 2);
  localparam logic [CNT_W-1:0] LOAD_CNT = CNT_W'(N_BITS);
  localparam logic [CNT_W-1:0] LOCK_CNT = CNT_W'(N_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  seq_state_e       state;

  always_ff @(posedge shift_clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!prog_en_i)        cnt_q <= '0;
    else if (cnt_q != LOCK_CNT) cnt_q <= cnt_q + CNT_ONE;
  end

  always_comb begin
    if (cnt_q == '0)           state = ST_IDLE;
    else if (cnt_q < LOAD_CNT) state = ST_SHIFT;
    else if (cnt_q == LOAD_CNT) state = ST_LOAD;
    else                       state = ST_LOCKED;
  end

  assign shift_o  = prog_en_i && (state == ST_IDLE || state == ST_SHIFT);
  assign load_o   = prog_en_i && (state == ST_LOAD);
  assign locked_o = (state == ST_LOCKED);

  // R8: an edge with the mode enable low returns to IDLE
  p_soft_reset_r8: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    !prog_en_i |=> (state == ST_IDLE) && !locked_o);

  // R7: LOCKED is held while programmable mode persists
  p_lock_sat_r7: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    (prog_en_i && locked_o) |=> locked_o);

  // R3: LOAD is followed by LOCKED
  p_load_next_r3: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    load_o |=> locked_o);
endmodule

// File: rtl/cfo_ctrl_reg.sv
`timescale 1ns/1ps
module cfo_ctrl_reg #(
  parameter int unsigned W = 11
) (
  input  logic         shift_clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge shift_clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  // R3: commit captures the shift register as it stood at the 12th edge
  p_commit_r3: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (q_o == $past(d_i)));
endmodule

// File: rtl/cfo_out_stage.sv
`timescale 1ns/1ps
module cfo_out_stage #(
  parameter int unsigned N_OUT = 10
) (
  input  logic             prog_en_i,
  input  logic             ser_data_i,
  input  logic             locked_i,
  input  logic [N_OUT:0]   ctrl_i,
  input  logic             ref_clk0_i,
  input  logic             ref_clk1_i,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] oe_o
);
  logic use_ctrl;
  logic sel;
  logic sel_clk;

  assign use_ctrl = prog_en_i && locked_i;

  always_comb begin
    if (!prog_en_i)    sel = ser_data_i;
    else if (locked_i) sel = ctrl_i[0];
    else               sel = 1'b0;
  end

  assign sel_clk = sel ? ref_clk1_i : ref_clk0_i;

  // stage j+1 holds the enable of output j (first bit shifted drives the top output)
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign oe_o[j]  = use_ctrl ? ctrl_i[j+1] : 1'b1;
    assign clk_o[j] = sel_clk & oe_o[j];
  end

  // R6: a disabled output never toggles
  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      if (!oe_o[j]) p_disabled_low_r6: assert (!clk_o[j]);
    end
  end
endmodule

// File: rtl/clk_fanout_cfg.sv
`timescale 1ns/1ps
module clk_fanout_cfg
  import cfo_pkg::*;
#(
  parameter int unsigned N_OUT = N_OUT_DEF
) (
  input  logic             rst_ni,
  input  logic             shift_clk_i,
  input  logic             ser_data_i,
  input  logic             prog_en_i,
  input  logic             ref_clk0_i,
  input  logic             ref_clk1_i,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] oe_o
);
  localparam int unsigned WORD_W = N_OUT + 1;

  logic              shift_en;
  logic              load_en;
  logic              locked;
  logic              soft_clr;
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] ctrl_q;

  assign soft_clr = !prog_en_i;

  cfo_sequencer #(.N_BITS(WORD_W)) i_seq (
    .shift_clk_i (shift_clk_i),
    .rst_ni      (rst_ni),
    .prog_en_i   (prog_en_i),
    .shift_o     (shift_en),
    .load_o      (load_en),
    .locked_o    (locked)
  );

  cfo_shift_reg #(.W(WORD_W)) i_sr (
    .shift_clk_i (shift_clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_clr),
    .shift_i     (shift_en),
    .ser_i       (ser_data_i),
    .q_o         (sr_q)
  );

  cfo_ctrl_reg #(.W(WORD_W)) i_ctrl (
    .shift_clk_i (shift_clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_clr),
    .load_i      (load_en),
    .d_i         (sr_q),
    .q_o         (ctrl_q)
  );

  cfo_out_stage #(.N_OUT(N_OUT)) i_out (
    .prog_en_i  (prog_en_i),
    .ser_data_i (ser_data_i),
    .locked_i   (locked),
    .ctrl_i     (ctrl_q),
    .ref_clk0_i (ref_clk0_i),
    .ref_clk1_i (ref_clk1_i),
    .clk_o      (clk_o),
    .oe_o       (oe_o)
  );

  // R7: configuration frozen once committed
  p_lock_hold_r7: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    (prog_en_i && locked) |=> $stable(ctrl_q));

  // R8: soft reset empties both registers
  p_soft_clear_r8: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    !prog_en_i |=> (sr_q == '0) && (ctrl_q == '0));
endmodule

// File: tb/test_clk_fanout_cfg.sv
`timescale 1ns/1ps
module test_clk_fanout_cfg;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         shift_clk = 1'b0;
  logic         ser = 1'b0;
  logic         prog_en = 1'b0;
  logic         ref0 = 1'b0;
  logic         ref1 = 1'b0;
  logic [N-1:0] clk_o;
  logic [N-1:0] oe_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  clk_fanout_cfg #(.N_OUT(N)) i_clk_fanout_cfg (
    .rst_ni      (rst_ni),
    .shift_clk_i (shift_clk),
    .ser_data_i  (ser),
    .prog_en_i   (prog_en),
    .ref_clk0_i  (ref0),
    .ref_clk1_i  (ref1),
    .clk_o       (clk_o),
    .oe_o        (oe_o)
  );

  localparam logic [N-1:0] ALL_ON = '1;

  // expected enables: shifted bit k drives output 9-k (R4)
  function automatic logic [N-1:0] map_oe(logic [N:0] seq);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[N-1-k] = seq[k];
    return r;
  endfunction

  task automatic cmp(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe,clk} actual %b expected %b", req, act, exp);
    end
  endtask

  // drive static reference levels both ways to read back the selection
  task automatic check_out(string req, logic [N-1:0] exp_oe, logic exp_sel);
    ref0 = 1'b1; ref1 = 1'b0; #1;
    cmp(req, {oe_o, clk_o}, {exp_oe, (exp_sel ? {N{1'b0}} : exp_oe)});
    ref0 = 1'b0; ref1 = 1'b1; #1;
    cmp(req, {oe_o, clk_o}, {exp_oe, (exp_sel ? exp_oe : {N{1'b0}})});
    ref0 = 1'b0; ref1 = 1'b0;
  endtask

  task automatic pulse(logic d);
    @(negedge clk) ser = d;
    @(posedge clk) shift_clk = 1'b1;
    @(negedge clk) shift_clk = 1'b0;
    #1;
  endtask

  task automatic soft_reset();
    @(negedge clk) prog_en = 1'b0;
    pulse(1'b0);
    @(negedge clk) prog_en = 1'b1;
  endtask

  task automatic shift_word(logic [N:0] seq);
    for (int k = 0; k <= N; k++) pulse(seq[k]);
  endtask

  task automatic t_reset();
    prog_en = 1'b1; ser = 1'b1; #5;
    check_out("R1", ALL_ON, 1'b0);
    prog_en = 1'b0; ser = 1'b0; #1;
    check_out("R11", ALL_ON, 1'b0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1 check_out("R11", ALL_ON, 1'b0);
  endtask

  task automatic t_std_mode();
    prog_en = 1'b0;
    ser = 1'b1; #1 check_out("R9", ALL_ON, 1'b1);
    ser = 1'b0; #1 check_out("R9", ALL_ON, 1'b0);
  endtask

  task automatic t_program(logic [N:0] seq);
    soft_reset();
    #1 check_out("R10", ALL_ON, 1'b0);
    shift_word(seq);
    check_out("R3", ALL_ON, 1'b0);       // 11 edges: not committed yet
    pulse(~seq[N]);                      // 12th edge commits
    check_out("R4", map_oe(seq), seq[N]);
    check_out("R5", map_oe(seq), seq[N]);
  endtask

  task automatic t_lock(logic [N:0] seq);
    t_program(seq);
    for (int i = 0; i < 14; i++) pulse(i[0] ^ i[2]);
    check_out("R7", map_oe(seq), seq[N]);
    // mode swap without a shift edge keeps the committed word
    @(negedge clk) prog_en = 1'b0; ser = 1'b1; #1;
    check_out("R9", ALL_ON, 1'b1);
    @(negedge clk) prog_en = 1'b1; #1;
    check_out("R9", map_oe(seq), seq[N]);
  endtask

  task automatic t_soft_reset(logic [N:0] seq);
    t_program(11'h7ff);
    soft_reset();
    #1 check_out("R8", ALL_ON, 1'b0);
    for (int i = 0; i < 5; i++) pulse(1'b0);   // partial load, then abandon
    soft_reset();
    shift_word(seq);
    pulse(1'b0);
    check_out("R8", map_oe(seq), seq[N]);
  endtask

  task automatic t_gating();
    // R6: disabled outputs stay low for both selections
    t_program(11'b1_1010010011);
    check_out("R6", map_oe(11'b1_1010010011), 1'b1);
    t_program(11'b0_0000000001);
    check_out("R6", map_oe(11'b0_0000000001), 1'b0);
  endtask

  initial begin
    t_reset();
    t_std_mode();
    t_program(11'b0_0000000001);   // R2: single marker bit locates the first stage
    t_program(11'b1_1000000000);
    t_program(11'b1_0110100110);
    t_lock(11'b0_1100101011);
    t_soft_reset(11'b1_0011110010);
    t_gating();
    @(negedge clk) prog_en = 1'b0; ser = 1'b0; #1;
    check_out("R11", ALL_ON, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule